// File: doc/BRIEF.md
# Address Attribute Strobe Generator

This block produces a single address-attribute strobe for an external memory bus. Each cycle in which an external access is presented, the block checks whether the memory space of that access (program, X data or Y data) has its enable set, and if so compares a programmable number of the most significant address bits against a stored base field. When both conditions hold, the strobe goes to its active level in the following cycle. The strobe can be used as a chip select for a memory region or as an extra decoded address line.

Software programs one configuration word. This word holds the three space enables, a polarity bit, a compare-width count and the base field. The word can be read back. The polarity bit selects whether the strobe is active high or active low. While no access is presented, the strobe sits at its inactive level.

Top module: `aas_strobe_gen`

## Requirements
- R1: A cycle with `cfg_wr` high loads `cfg_wdata` into the configuration word. Its fields are: enables in bits [2:0], polarity in bit 3, compare count in bits [7:4] and base in bits [19:8]. `cfg_rdata` shows the stored word from the next cycle on. A count value above BASE_W (12) is stored as BASE_W.
- R2: Bits [23:20] of `cfg_rdata` are reserved and always read 0, whatever was written to them.
- R3: While `rst` is high, the configuration word clears to 0. The strobe output then reads 1, which is the inactive level for polarity 0.
- R4: `acc_space` selects an enable: 2'b00 is program space (bit 0), 2'b01 is X data (bit 1) and 2'b10 is Y data (bit 2). An access in a space whose enable is clear never activates the strobe. Code 2'b11 never activates it either.
- R5: With compare count N (1..12), an access in an enabled space matches when `acc_addr[23:24-N]` equals base bits [11:12-N]. Address bits below that range have no effect.
- R6: With compare count 0, every access in an enabled space matches.
- R7: Polarity 0 makes the active strobe level 0 and the inactive level 1. Polarity 1 makes the active level 1 and the inactive level 0.
- R8: The strobe is registered. It shows the result of the access presented in cycle t during cycle t+1. It is at the inactive level in the cycle after any cycle in which `acc_valid` is low.
- R9: A polarity change written at clock edge k moves the idle strobe to the new inactive level at edge k+1, with no access needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 24 | Configuration write data |
| cfg_rdata | output | 24 | Configuration read-back |
| acc_valid | input | 1 | External access present this cycle |
| acc_space | input | 2 | Memory space of the access |
| acc_addr | input | 24 | External address of the access |
| attr_strobe | output | 1 | Registered address-attribute strobe |

## Verification
Configuration writes become visible on `cfg_rdata` one clock edge after the write. An access decision reaches `attr_strobe` one edge after the access is presented. A polarity write reaches the idle strobe two edges after it is presented: one edge to store the bit and one edge to register the strobe. The bench drives inputs on the falling edge and samples on the falling edge that follows the relevant rising edge. The R9 check samples both between the two edges and after the second one, so it confirms the level changes at exactly that point. The sweep covers every enable pattern, both polarities, every compare count and all four space codes. Its addresses flip the bits just inside and just outside the compared range.

// File: rtl/aas_pkg.sv
package aas_pkg;

    // Memory space codes carried on acc_space
    typedef enum logic [1:0] {
        SPACE_PROG  = 2'b00,
        SPACE_XDATA = 2'b01,
        SPACE_YDATA = 2'b10,
        SPACE_NONE  = 2'b11
    } space_e;

    // Control bits of the configuration word
    typedef struct packed {
        logic       pol;   // 1: active high strobe
        logic [2:0] en;    // {y, x, prog}
    } ctl_t;

    localparam int EN_LSB      = 0;
    localparam int POL_BIT     = 3;
    localparam int CNT_LSB     = 4;
    localparam int CNT_FIELD_W = 4;
    localparam int BASE_LSB    = CNT_LSB + CNT_FIELD_W;

    function automatic logic space_enabled(input ctl_t c, input space_e s);
        case (s)
            SPACE_PROG:  return c.en[0];
            SPACE_XDATA: return c.en[1];
            SPACE_YDATA: return c.en[2];
            default:     return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/aas_cfg_reg.sv
module aas_cfg_reg
    import aas_pkg::*;
#(
    parameter int BASE_W = 12,
    parameter int CFG_W  = 24
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [CFG_W-1:0]       wr_data,
    output ctl_t                   ctl,
    output logic [CNT_FIELD_W-1:0] count,
    output logic [BASE_W-1:0]      base,
    output logic [CFG_W-1:0]       rd_data
);
    localparam int USED_W = BASE_LSB + BASE_W;
    localparam int RSV_W  = CFG_W - USED_W;

    logic [CNT_FIELD_W-1:0] wr_count;
    logic [CNT_FIELD_W-1:0] wr_count_sat;

    assign wr_count     = wr_data[CNT_LSB +: CNT_FIELD_W];
    assign wr_count_sat = (int'(wr_count) > BASE_W) ? CNT_FIELD_W'(BASE_W) : wr_count;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl   <= '0;
            count <= '0;
            base  <= '0;
        end else if (wr_en) begin
            ctl.en  <= wr_data[EN_LSB +: 3];
            ctl.pol <= wr_data[POL_BIT];
            count   <= wr_count_sat;
            base    <= wr_data[BASE_LSB +: BASE_W];
        end
    end

    generate
        if (RSV_W > 0) begin : g_rsv
            assign rd_data = {{RSV_W{1'b0}}, base, count, ctl.pol, ctl.en};
        end else begin : g_norsv
            assign rd_data = {base, count, ctl.pol, ctl.en};
        end
    endgenerate

    // R1: stored count never exceeds the compare field width
    a_r1_count_saturated: assert property (@(posedge clk) disable iff (rst)
        int'(count) <= BASE_W);

    // R3: reset clears the whole word
    a_r3_reset_clears: assert property (@(posedge clk)
        rst |=> (rd_data == '0));

endmodule

// File: rtl/aas_match.sv
module aas_match
    import aas_pkg::*;
#(
    parameter int BASE_W = 12
) (
    input  logic [BASE_W-1:0]      addr_hi,
    input  logic [BASE_W-1:0]      base,
    input  logic [CNT_FIELD_W-1:0] count,
    output logic                   hit
);
    logic [BASE_W-1:0] bit_ok;

    // Bit i takes part when it lies within the top `count` bits
    generate
        for (genvar i = 0; i < BASE_W; i++) begin : g_bit
            logic used;
            assign used      = (int'(count) + i) >= BASE_W;
            assign bit_ok[i] = !used || (addr_hi[i] == base[i]);
        end
    endgenerate

    assign hit = &bit_ok;

endmodule

// File: rtl/aas_strobe_gen.sv
module aas_strobe_gen
    import aas_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int BASE_W = 12,
    parameter int CFG_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              acc_valid,
    input  logic [1:0]        acc_space,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              attr_strobe
);
    localparam int LO_W = ADDR_W - BASE_W;

    ctl_t                   ctl;
    logic [CNT_FIELD_W-1:0] count;
    logic [BASE_W-1:0]      base;
    logic [BASE_W-1:0]      addr_hi;
    logic                   hit;
    logic                   space_ok;
    logic                   fire;
    logic                   unused_addr_lo;

    assign addr_hi        = acc_addr[ADDR_W-1 -: BASE_W];
    assign unused_addr_lo = ^acc_addr[LO_W-1:0];

    aas_cfg_reg #(.BASE_W(BASE_W), .CFG_W(CFG_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr),
        .wr_data (cfg_wdata),
        .ctl     (ctl),
        .count   (count),
        .base    (base),
        .rd_data (cfg_rdata)
    );

    aas_match #(.BASE_W(BASE_W)) u_match (
        .addr_hi (addr_hi),
        .base    (base),
        .count   (count),
        .hit     (hit)
    );

    assign space_ok = space_enabled(ctl, space_e'(acc_space));
    assign fire     = acc_valid && space_ok && hit;

    always_ff @(posedge clk) begin
        if (rst) attr_strobe <= 1'b1;
        else     attr_strobe <= fire ? ctl.pol : ~ctl.pol;
    end

    // R8: idle cycle yields the inactive level next cycle
    a_r8_idle_inactive: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> (attr_strobe == !$past(ctl.pol)));

    // R4: disabled space or reserved code never activates
    a_r4_disabled_space: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !space_ok) |=> (attr_strobe == !$past(ctl.pol)));

    // R6: zero compare count matches any address in an enabled space
    a_r6_count_zero_hits: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && space_ok && count == '0) |=> (attr_strobe == $past(ctl.pol)));

    // R2: reserved read-back bits are zero
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[CFG_W-1:BASE_LSB+BASE_W] == '0);

endmodule

// File: tb/aas_strobe_gen_test.sv
`timescale 1ns/1ps
module aas_strobe_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [23:0] cfg_wdata = '0;
    logic [23:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_space = '0;
    logic [23:0] acc_addr = '0;
    logic        attr_strobe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    aas_strobe_gen uut (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr      (cfg_wr),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .acc_valid   (acc_valid),
        .acc_space   (acc_space),
        .acc_addr    (acc_addr),
        .attr_strobe (attr_strobe)
    );

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [23:0] mk_cfg(input logic [2:0] en, input logic pol,
                                           input logic [3:0] cnt, input logic [11:0] base);
        return {4'h0, base, cnt, pol, en};
    endfunction

    // Write one word; returns at the falling edge after the storing edge
    task automatic wr_cfg(input logic [23:0] d);
        cfg_wr = 1'b1;
        cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    function automatic logic exp_match(input logic [11:0] hi, input logic [11:0] base, input int cnt);
        logic [11:0] d;
        d = hi ^ base;
        if (cnt == 0) return 1'b1;
        return (d >> (12 - cnt)) == 12'h0;
    endfunction

    task automatic access(input logic [1:0] sp, input logic [23:0] a, input logic exp_lvl,
                          input logic idle_lvl, input string req);
        acc_valid = 1'b1;
        acc_space = sp;
        acc_addr  = a;
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0;
        chk(req, {23'h0, attr_strobe}, {23'h0, exp_lvl});
        @(posedge clk);
        @(negedge clk);
        chk("R8 idle", {23'h0, attr_strobe}, {23'h0, idle_lvl});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [11:0] bases [2];
        bases[0] = 12'hA5C;
        bases[1] = 12'h3F1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R3: reset state
        chk("R3 cfg", cfg_rdata, 24'h0);
        chk("R3 strobe", {23'h0, attr_strobe}, 24'h1);
        rst = 1'b0;
        @(negedge clk);

        // R1 readback and count saturation, R2 reserved bits
        wr_cfg(mk_cfg(3'b101, 1'b1, 4'd7, 12'h9E2));
        chk("R1 readback", cfg_rdata, mk_cfg(3'b101, 1'b1, 4'd7, 12'h9E2));
        wr_cfg(24'hFFFFFF);
        chk("R1 R2 saturate+reserved", cfg_rdata, {4'h0, 12'hFFF, 4'd12, 1'b1, 3'b111});
        wr_cfg(mk_cfg(3'b000, 1'b0, 4'd13, 12'h000));
        chk("R1 count13", cfg_rdata[7:4], 24'd12);

        // R9: polarity change without access
        wr_cfg(mk_cfg(3'b000, 1'b0, 4'd0, 12'h0));
        @(posedge clk); @(negedge clk);
        chk("R9 idle pol0", {23'h0, attr_strobe}, 24'h1);
        wr_cfg(mk_cfg(3'b000, 1'b1, 4'd0, 12'h0));
        chk("R9 before edge", {23'h0, attr_strobe}, 24'h1);
        @(posedge clk); @(negedge clk);
        chk("R9 after edge", {23'h0, attr_strobe}, 24'h0);
        wr_cfg(mk_cfg(3'b000, 1'b0, 4'd0, 12'h0));
        @(posedge clk); @(negedge clk);
        chk("R9 back to pol0", {23'h0, attr_strobe}, 24'h1);

        // Sweep R4 R5 R6 R7
        for (int b = 0; b < 2; b++) begin
            for (int en = 0; en < 8; en++) begin
                for (int pol = 0; pol < 2; pol++) begin
                    for (int cnt = 0; cnt <= 12; cnt++) begin
                        wr_cfg(mk_cfg(en[2:0], pol[0], cnt[3:0], bases[b]));
                        for (int sp = 0; sp < 4; sp++) begin
                            for (int v = 0; v < 4; v++) begin
                                logic [11:0] hi;
                                logic [11:0] lo;
                                logic act;
                                logic el;
                                lo = 12'h5A3 ^ 12'(v * 12'h111);
                                case (v)
                                    0: hi = bases[b];
                                    1: hi = (cnt > 0)  ? bases[b] ^ (12'h1 << (12 - cnt)) : ~bases[b];
                                    2: hi = (cnt < 12) ? bases[b] ^ (12'h1 << (11 - cnt)) : bases[b];
                                    default: hi = ~bases[b];
                                endcase
                                act = (sp != 3) && en[sp] && exp_match(hi, bases[b], cnt);
                                el = act ? pol[0] : ~pol[0];
                                access(sp[1:0], {hi, lo}, el, ~pol[0],
                                       (sp == 3 || !en[sp]) ? "R4 gating" :
                                       (cnt == 0) ? "R6 count0" :
                                       pol[0] ? "R5 R7 high" : "R5 R7 low");
                            end
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule